// File: doc/BRIEF.md
# Privilege Status and Exception-Return Control

This block keeps the processor status word and the privilege logic that depends on it. A coprocessor register port writes and reads four registers by index: the status word, a free-running cycle counter, the saved exception PC and the saved error PC. Three one-cycle command inputs request an exception return, an interrupt enable and an interrupt disable. From the status word the block derives the current privilege mode and the interrupt-enable level.

There are two exception levels, a normal one and an error one, and each has its own saved PC. An exception return leaves the error level if it is set and otherwise leaves the normal level. It also sends out a one-cycle redirect strobe with the matching saved PC. Interrupt enable and disable commands only act when the core is privileged or when an override bit in the status word allows them. Reads of the status word are filtered by a fixed mask. The counter advances on every clock, so two reads in a row always return different values.

Top module: `priv_status_ctrl`

## Requirements
- R1: Status bit positions are: exception level EXL at bit 1, error level ERL at bit 2, the user/supervisor field KSU at bits 4:3, the interrupt-enable level EIE at bit 16 and the enable-override EDI at bit 17. `priv_mode` is 0 (kernel) whenever EXL is set, ERL is set or KSU is 0. Otherwise it equals KSU. It reflects a status write from the cycle after the write.
- R2: An exception return with ERL set clears ERL, leaves EXL unchanged and redirects to the error PC.
- R3: An exception return with ERL clear clears EXL and redirects to the exception PC.
- R4: `redir_valid` is high for exactly the one cycle after each `cmd_eret` cycle and is low otherwise. It carries the PC selected from the register values at command time.
- R5: `cmd_ei` sets EIE and `cmd_di` clears it, but only when EDI, EXL or ERL is set or KSU is 0. Otherwise the status word is unchanged. `int_en` shows EIE.
- R6: When `cmd_ei` and `cmd_di` arrive in the same permitted cycle, EIE ends up clear.
- R7: Status is register index 12. A read returns the stored word ANDed with 0xF0C79C1F.
- R8: The counter is register index 9. It increments by one on every clock in which it is not written, and it wraps from 0xFFFFFFFF to 0.
- R9: A write to index 9 loads the counter, and counting continues from the loaded value.
- R10: Two reads of index 9 in consecutive cycles return different values.
- R11: The exception PC is at index 14 and the error PC at index 30. Both can be written and read back. Any other index reads as 0. Read data appears with `reg_rd_valid` one cycle after `reg_rd_en`.
- R12: After reset the status word is 0x00000004 (ERL set, kernel mode). The counter and both saved PCs are 0, and both strobes are low.
- R13: A status write in the same cycle as any command takes precedence. The status word then becomes exactly the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write request |
| reg_rd_en | input | 1 | Register read request |
| reg_idx | input | 5 | Register index |
| reg_wdata | input | 32 | Write data |
| cmd_eret | input | 1 | Exception-return command |
| cmd_ei | input | 1 | Interrupt-enable command |
| cmd_di | input | 1 | Interrupt-disable command |
| reg_rd_valid | output | 1 | Read data valid |
| reg_rdata | output | 32 | Read data |
| priv_mode | output | 2 | Privilege mode: 0 kernel, 1 supervisor, 2 user |
| int_en | output | 1 | Interrupt-enable level |
| redir_valid | output | 1 | Redirect strobe after exception return |
| redir_pc | output | 32 | Redirect target PC |

## Verification
Directed sequences set each combination of EXL, ERL and KSU. They separate kernel forcing from KSU pass-through and show whether enable commands are gated or obeyed. Two back-to-back returns with both levels set tell the error-PC path apart from the normal one. Counter loads near the top of the range expose the wrap. A long random mix of writes, reads and overlapping commands, run against a behavioural model, shows the ordering between a status write and commands in the same cycle.

// File: rtl/psc_pkg.sv
package psc_pkg;
   localparam int ST_IE     = 0;
   localparam int ST_EXL    = 1;
   localparam int ST_ERL    = 2;
   localparam int ST_KSU_LO = 3;
   localparam int ST_KSU_HI = 4;
   localparam int ST_EIE    = 16;
   localparam int ST_EDI    = 17;
   localparam int ST_MIN_W  = ST_EDI + 1;

   localparam int REG_COUNT   = 9;
   localparam int REG_STATUS  = 12;
   localparam int REG_EPC     = 14;
   localparam int REG_ERR_EPC = 30;

   typedef enum logic [1:0] {
      MODE_KERNEL = 2'd0,
      MODE_SUPER  = 2'd1,
      MODE_USER   = 2'd2,
      MODE_RSVD   = 2'd3
   } priv_mode_e;
endpackage

// File: rtl/psc_status_unit.sv
module psc_status_unit
   import psc_pkg::*;
#(
   parameter int              DATA_W  = 32,
   parameter logic [DATA_W-1:0] RST_VAL = DATA_W'(4)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              cmd_eret,
   input  logic              cmd_ei,
   input  logic              cmd_di,
   output logic [DATA_W-1:0] status_q,
   output logic              err_level,
   output priv_mode_e        mode,
   output logic              int_en
);
   logic [DATA_W-1:0] status_d;
   logic [1:0]        ksu;
   logic              privileged;
   logic              gate_ok;

   assign ksu        = status_q[ST_KSU_HI:ST_KSU_LO];
   assign privileged = status_q[ST_EXL] | status_q[ST_ERL] | (ksu == 2'd0);
   assign gate_ok    = privileged | status_q[ST_EDI];

   always_comb begin
      status_d = status_q;
      if (cmd_eret) begin
         if (status_q[ST_ERL]) status_d[ST_ERL] = 1'b0;
         else                  status_d[ST_EXL] = 1'b0;
      end
      if (gate_ok) begin
         if (cmd_ei) status_d[ST_EIE] = 1'b1;
         if (cmd_di) status_d[ST_EIE] = 1'b0;
      end
      if (wr_en) status_d = wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q <= RST_VAL;
      else        status_q <= status_d;
   end

   always_comb begin
      if (privileged) mode = MODE_KERNEL;
      else            mode = priv_mode_e'(ksu);
   end

   assign err_level = status_q[ST_ERL];
   assign int_en    = status_q[ST_EIE];
endmodule

// File: rtl/psc_cycle_counter.sv
module psc_cycle_counter #(
   parameter int W    = 32,
   parameter int STEP = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] count_q
);
   localparam logic [W-1:0] INC = W'(STEP);

   if (STEP < 1) begin : g_bad_step
      $error("psc_cycle_counter: STEP must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    count_q <= '0;
      else if (load) count_q <= load_val;
      else           count_q <= count_q + INC;
   end
endmodule

// File: rtl/psc_return_unit.sv
module psc_return_unit #(
   parameter int PC_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_epc,
   input  logic            wr_err_epc,
   input  logic [PC_W-1:0] wdata,
   input  logic            cmd_eret,
   input  logic            use_err,
   output logic [PC_W-1:0] epc_q,
   output logic [PC_W-1:0] err_epc_q,
   output logic            redir_valid,
   output logic [PC_W-1:0] redir_pc
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         epc_q     <= '0;
         err_epc_q <= '0;
      end else begin
         if (wr_epc)     epc_q     <= wdata;
         if (wr_err_epc) err_epc_q <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         redir_valid <= 1'b0;
         redir_pc    <= '0;
      end else begin
         redir_valid <= cmd_eret;
         if (cmd_eret) redir_pc <= use_err ? err_epc_q : epc_q;
      end
   end
endmodule

// File: rtl/psc_read_mux.sv
module psc_read_mux
   import psc_pkg::*;
#(
   parameter int                DATA_W   = 32,
   parameter int                IDX_W    = 5,
   parameter logic [DATA_W-1:0] RD_MASK  = DATA_W'(32'hF0C7_9C1F),
   parameter bit                READ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] status_q,
   input  logic [DATA_W-1:0] count_q,
   input  logic [DATA_W-1:0] epc_q,
   input  logic [DATA_W-1:0] err_epc_q,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);
   localparam logic [IDX_W-1:0] I_CNT = IDX_W'(REG_COUNT);
   localparam logic [IDX_W-1:0] I_ST  = IDX_W'(REG_STATUS);
   localparam logic [IDX_W-1:0] I_EPC = IDX_W'(REG_EPC);
   localparam logic [IDX_W-1:0] I_ERR = IDX_W'(REG_ERR_EPC);

   logic [DATA_W-1:0] sel;

   always_comb begin
      case (idx)
         I_CNT:   sel = count_q;
         I_ST:    sel = status_q & RD_MASK;
         I_EPC:   sel = epc_q;
         I_ERR:   sel = err_epc_q;
         default: sel = '0;
      endcase
   end

   if (READ_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
         end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= sel;
         end
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign rd_valid   = rd_en;
      assign rd_data    = rd_en ? sel : '0;
   end
endmodule

// File: rtl/priv_status_ctrl.sv
module priv_status_ctrl
   import psc_pkg::*;
#(
   parameter int                DATA_W    = 32,
   parameter int                IDX_W     = 5,
   parameter logic [DATA_W-1:0] STATUS_RST = DATA_W'(4),
   parameter logic [DATA_W-1:0] STATUS_RD_MASK = DATA_W'(32'hF0C7_9C1F),
   parameter bit                READ_REG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic              reg_rd_en,
   input  logic [IDX_W-1:0]  reg_idx,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              cmd_eret,
   input  logic              cmd_ei,
   input  logic              cmd_di,
   output logic              reg_rd_valid,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [1:0]        priv_mode,
   output logic              int_en,
   output logic              redir_valid,
   output logic [DATA_W-1:0] redir_pc
);
   localparam int MAX_IDX = (1 << IDX_W) - 1;

   if (DATA_W < ST_MIN_W) begin : g_bad_width
      $error("priv_status_ctrl: DATA_W too narrow for status fields");
   end
   if (MAX_IDX < REG_ERR_EPC) begin : g_bad_idx
      $error("priv_status_ctrl: IDX_W cannot address all registers");
   end

   logic              wr_status, wr_count, wr_epc, wr_err_epc;
   logic [DATA_W-1:0] status_q, count_q, epc_q, err_epc_q;
   logic              err_level;
   priv_mode_e        mode;

   assign wr_status  = reg_wr_en && (reg_idx == IDX_W'(REG_STATUS));
   assign wr_count   = reg_wr_en && (reg_idx == IDX_W'(REG_COUNT));
   assign wr_epc     = reg_wr_en && (reg_idx == IDX_W'(REG_EPC));
   assign wr_err_epc = reg_wr_en && (reg_idx == IDX_W'(REG_ERR_EPC));

   psc_status_unit #(.DATA_W(DATA_W), .RST_VAL(STATUS_RST)) u_status (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_status), .wdata(reg_wdata),
      .cmd_eret(cmd_eret), .cmd_ei(cmd_ei), .cmd_di(cmd_di),
      .status_q(status_q), .err_level(err_level), .mode(mode), .int_en(int_en)
   );

   psc_cycle_counter #(.W(DATA_W), .STEP(1)) u_count (
      .clk(clk), .rst_n(rst_n), .load(wr_count), .load_val(reg_wdata),
      .count_q(count_q)
   );

   psc_return_unit #(.PC_W(DATA_W)) u_ret (
      .clk(clk), .rst_n(rst_n), .wr_epc(wr_epc), .wr_err_epc(wr_err_epc),
      .wdata(reg_wdata), .cmd_eret(cmd_eret), .use_err(err_level),
      .epc_q(epc_q), .err_epc_q(err_epc_q),
      .redir_valid(redir_valid), .redir_pc(redir_pc)
   );

   psc_read_mux #(
      .DATA_W(DATA_W), .IDX_W(IDX_W), .RD_MASK(STATUS_RD_MASK), .READ_REG(READ_REG)
   ) u_rd (
      .clk(clk), .rst_n(rst_n), .rd_en(reg_rd_en), .idx(reg_idx),
      .status_q(status_q), .count_q(count_q), .epc_q(epc_q), .err_epc_q(err_epc_q),
      .rd_valid(reg_rd_valid), .rd_data(reg_rdata)
   );

   assign priv_mode = mode;
endmodule

// File: rtl/psc_chk.sv
module psc_chk
   import psc_pkg::*;
#(
   parameter int                DATA_W   = 32,
   parameter int                IDX_W    = 5,
   parameter logic [DATA_W-1:0] RD_MASK  = DATA_W'(32'hF0C7_9C1F),
   parameter bit                READ_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr_en,
   input logic              reg_rd_en,
   input logic [IDX_W-1:0]  reg_idx,
   input logic [DATA_W-1:0] reg_wdata,
   input logic              cmd_eret,
   input logic              cmd_ei,
   input logic              cmd_di,
   input logic              reg_rd_valid,
   input logic [DATA_W-1:0] reg_rdata,
   input logic [1:0]        priv_mode,
   input logic              redir_valid,
   input logic [DATA_W-1:0] status_q,
   input logic [DATA_W-1:0] count_q
);
   logic st_wr, cnt_wr, lvl, gate;
   assign st_wr  = reg_wr_en && (reg_idx == IDX_W'(REG_STATUS));
   assign cnt_wr = reg_wr_en && (reg_idx == IDX_W'(REG_COUNT));
   assign lvl    = status_q[ST_EXL] | status_q[ST_ERL];
   assign gate   = lvl | status_q[ST_EDI] | (status_q[ST_KSU_HI:ST_KSU_LO] == 2'd0);

   assert_kernel_on_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
      lvl |-> (priv_mode == 2'd0));
   assert_ksu_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !lvl |-> (priv_mode == status_q[ST_KSU_HI:ST_KSU_LO]));
   assert_erl_leave_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_eret && status_q[ST_ERL] && !st_wr) |=> !status_q[ST_ERL]);
   assert_exl_leave_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_eret && !status_q[ST_ERL] && !st_wr) |=> !status_q[ST_EXL]);
   assert_redir_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_eret |=> redir_valid);
   assert_redir_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_eret |=> !redir_valid);
   assert_ei_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd_ei || cmd_di) && !gate && !st_wr) |=> $stable(status_q[ST_EIE]));
   assert_di_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_ei && cmd_di && gate && !st_wr) |=> !status_q[ST_EIE]);
   assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_wr |=> (count_q == $past(count_q) + DATA_W'(1)));
   assert_count_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (count_q == $past(reg_wdata)));
   assert_status_write_R13: assert property (@(posedge clk) disable iff (!rst_n)
      st_wr |=> (status_q == $past(reg_wdata)));

   if (READ_REG) begin : g_rd_reg
      assert_rd_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_rd_en && reg_idx == IDX_W'(REG_STATUS)) |=> ((reg_rdata & ~RD_MASK) == '0));
      assert_rd_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
         reg_rd_en |=> reg_rd_valid);
   end else begin : g_rd_comb
      always_comb begin
         if (rst_n && reg_rd_en && reg_idx == IDX_W'(REG_STATUS))
            assert_rd_mask_R7: assert ((reg_rdata & ~RD_MASK) == '0);
         if (rst_n)
            assert_rd_valid_R11: assert (reg_rd_valid == reg_rd_en);
      end
   end
endmodule

bind priv_status_ctrl psc_chk #(
   .DATA_W(DATA_W), .IDX_W(IDX_W), .RD_MASK(STATUS_RD_MASK), .READ_REG(READ_REG)
) u_psc_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
   .reg_idx(reg_idx), .reg_wdata(reg_wdata), .cmd_eret(cmd_eret),
   .cmd_ei(cmd_ei), .cmd_di(cmd_di), .reg_rd_valid(reg_rd_valid),
   .reg_rdata(reg_rdata), .priv_mode(priv_mode), .redir_valid(redir_valid),
   .status_q(status_q), .count_q(count_q)
);

// File: tb/tb_priv_status_ctrl.sv
`timescale 1ns/1ps
module tb_priv_status_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 0, reg_rd_en = 0, cmd_eret = 0, cmd_ei = 0, cmd_di = 0;
   logic [4:0]  reg_idx = '0;
   logic [31:0] reg_wdata = '0;
   logic        reg_rd_valid, int_en, redir_valid;
   logic [31:0] reg_rdata, redir_pc;
   logic [1:0]  priv_mode;

   int n_tests = 0;
   int n_fail  = 0;

   always #2.5 clk = ~clk;

   priv_status_ctrl dut (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
      .reg_idx(reg_idx), .reg_wdata(reg_wdata), .cmd_eret(cmd_eret),
      .cmd_ei(cmd_ei), .cmd_di(cmd_di), .reg_rd_valid(reg_rd_valid),
      .reg_rdata(reg_rdata), .priv_mode(priv_mode), .int_en(int_en),
      .redir_valid(redir_valid), .redir_pc(redir_pc)
   );

   // behavioural reference model
   logic [31:0] m_st, m_cnt, m_epc, m_eepc, m_rd, m_xpc;
   logic        m_rv, m_xv;
   string       m_rtag, m_xtag;

   function automatic logic [1:0] mode_of(input logic [31:0] s);
      if (s[1] || s[2] || s[4:3] == 2'd0) return 2'd0;
      return s[4:3];
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 32'h4; m_cnt = 0; m_epc = 0; m_eepc = 0;
         m_rv = 0; m_rd = 0; m_xv = 0; m_xpc = 0;
         m_rtag = "R12"; m_xtag = "R12";
      end else begin
         logic [31:0] s;
         logic ok;
         m_rv = reg_rd_en;
         if (reg_rd_en) begin
            case (reg_idx)
               5'd9:    begin m_rd = m_cnt;                 m_rtag = "R8";  end
               5'd12:   begin m_rd = m_st & 32'hF0C79C1F;   m_rtag = "R7";  end
               5'd14:   begin m_rd = m_epc;                 m_rtag = "R11"; end
               5'd30:   begin m_rd = m_eepc;                m_rtag = "R11"; end
               default: begin m_rd = 0;                     m_rtag = "R11"; end
            endcase
         end
         m_xv = cmd_eret;
         if (cmd_eret) begin
            m_xpc  = m_st[2] ? m_eepc : m_epc;
            m_xtag = m_st[2] ? "R2" : "R3";
         end
         s  = m_st;
         ok = m_st[17] | m_st[1] | m_st[2] | (m_st[4:3] == 0);
         if (cmd_eret) begin
            if (s[2]) s[2] = 0; else s[1] = 0;
         end
         if (ok && cmd_ei) s[16] = 1;
         if (ok && cmd_di) s[16] = 0;
         if (reg_wr_en && reg_idx == 5'd12) s = reg_wdata;
         m_st  = s;
         m_cnt = (reg_wr_en && reg_idx == 5'd9) ? reg_wdata : m_cnt + 1;
         if (reg_wr_en && reg_idx == 5'd14) m_epc  = reg_wdata;
         if (reg_wr_en && reg_idx == 5'd30) m_eepc = reg_wdata;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare();
      chk(priv_mode == mode_of(m_st), "R1", 32'(priv_mode), 32'(mode_of(m_st)));
      chk(int_en == m_st[16], "R5", 32'(int_en), 32'(m_st[16]));
      chk(redir_valid == m_xv, "R4", 32'(redir_valid), 32'(m_xv));
      if (m_xv) chk(redir_pc == m_xpc, m_xtag, redir_pc, m_xpc);
      chk(reg_rd_valid == m_rv, "R11", 32'(reg_rd_valid), 32'(m_rv));
      if (m_rv) chk(reg_rdata == m_rd, m_rtag, reg_rdata, m_rd);
   endtask

   task automatic cyc(input bit wr, input bit rd, input logic [4:0] idx, input logic [31:0] wd,
                      input bit er, input bit ei, input bit di);
      reg_wr_en = wr; reg_rd_en = rd; reg_idx = idx; reg_wdata = wd;
      cmd_eret = er; cmd_ei = ei; cmd_di = di;
      @(negedge clk);
      reg_wr_en = 0; reg_rd_en = 0; cmd_eret = 0; cmd_ei = 0; cmd_di = 0;
      compare();
   endtask

   initial begin
      #(5.0 * 150000);
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] a, b;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R12 reset state
      chk(priv_mode == 0 && int_en == 0 && !redir_valid && !reg_rd_valid, "R12",
          {28'd0, priv_mode, int_en, redir_valid}, 32'd0);
      cyc(0, 1, 5'd12, 0, 0, 0, 0);
      chk(reg_rdata == 32'h4, "R12", reg_rdata, 32'h4);
      // R1 user mode, R5 gated EI
      cyc(1, 0, 5'd12, 32'h10, 0, 0, 0);
      chk(priv_mode == 2'd2, "R1", 32'(priv_mode), 2);
      cyc(0, 0, 0, 0, 0, 1, 0);
      chk(int_en == 0, "R5", 32'(int_en), 0);
      // override lets EI through
      cyc(1, 0, 5'd12, 32'h20008, 0, 0, 0);
      chk(priv_mode == 2'd1, "R1", 32'(priv_mode), 1);
      cyc(0, 0, 0, 0, 0, 1, 0);
      chk(int_en == 1, "R5", 32'(int_en), 1);
      cyc(0, 0, 0, 0, 0, 1, 1);
      chk(int_en == 0, "R6", 32'(int_en), 0);
      // R2/R3 return order
      cyc(1, 0, 5'd14, 32'h8000_0180, 0, 0, 0);
      cyc(1, 0, 5'd30, 32'hBFC0_0300, 0, 0, 0);
      cyc(1, 0, 5'd12, 32'h16, 0, 0, 0);
      chk(priv_mode == 0, "R1", 32'(priv_mode), 0);
      cyc(0, 0, 0, 0, 1, 0, 0);
      chk(redir_valid && redir_pc == 32'hBFC0_0300, "R2", redir_pc, 32'hBFC0_0300);
      cyc(0, 0, 0, 0, 1, 0, 0);
      chk(redir_valid && redir_pc == 32'h8000_0180, "R3", redir_pc, 32'h8000_0180);
      chk(priv_mode == 2'd2, "R3", 32'(priv_mode), 2);
      cyc(0, 0, 0, 0, 0, 0, 0);
      chk(!redir_valid, "R4", 32'(redir_valid), 0);
      // R7 mask
      cyc(1, 0, 5'd12, 32'hFFFF_FFFF, 0, 0, 0);
      cyc(0, 1, 5'd12, 0, 0, 0, 0);
      chk(reg_rdata == 32'hF0C79C1F, "R7", reg_rdata, 32'hF0C79C1F);
      // R9 load and R8 wrap
      cyc(1, 0, 5'd9, 32'hFFFF_FFFE, 0, 0, 0);
      cyc(0, 1, 5'd9, 0, 0, 0, 0);
      chk(reg_rdata == 32'hFFFF_FFFE, "R9", reg_rdata, 32'hFFFF_FFFE);
      cyc(0, 1, 5'd9, 0, 0, 0, 0);
      a = reg_rdata;
      cyc(0, 1, 5'd9, 0, 0, 0, 0);
      b = reg_rdata;
      chk(b == 32'd0, "R8", b, 0);
      chk(a != b, "R10", b, a);
      // R11 unmapped and saved PCs
      cyc(0, 1, 5'd3, 0, 0, 0, 0);
      chk(reg_rdata == 0, "R11", reg_rdata, 0);
      cyc(0, 1, 5'd30, 0, 0, 0, 0);
      chk(reg_rdata == 32'hBFC0_0300, "R11", reg_rdata, 32'hBFC0_0300);
      // R13 write beats commands
      cyc(1, 0, 5'd12, 32'h6, 0, 0, 0);
      cyc(1, 0, 5'd12, 32'h10, 1, 1, 0);
      chk(priv_mode == 2'd2 && int_en == 0, "R13", {30'd0, priv_mode}, 2);
      // random mix against the model
      for (int i = 0; i < 600; i++) begin
         logic [4:0] ix;
         case ($urandom_range(0, 4))
            0: ix = 5'd9; 1: ix = 5'd12; 2: ix = 5'd14; 3: ix = 5'd30; default: ix = 5'd7;
         endcase
         cyc($urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1, ix,
             ($urandom_range(0, 1) == 1) ? {$urandom} & 32'h0003_001F : $urandom,
             $urandom_range(0, 3) == 0, $urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0);
      end
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule